// File: doc/BRIEF.md
# Two-Wire Slave Port with 14-Bit Internal Addressing

This block is the host access port of a display controller. A host on a two-wire serial bus (I2C protocol, SCL up to 1 MHz) reaches a 16 KB internal address space through it. That space holds a 1 KB display RAM at the bottom, a font ROM window from 0x2000 to 0x32FF, and sixteen control registers at 0x3FF0 to 0x3FFF. All other addresses are empty. The block drives a simple synchronous memory bus that carries one-cycle read and write strobes.

A write transfer names the device and then sends two internal address bytes. The low byte comes first. The high byte carries A13..A8 in its six low bits. Any number of data bytes follow, each stored at the next address. To read, the host first sets the address with a write-mode transfer. It then opens a read-mode transfer, with or without a STOP in between, and takes bytes from successive addresses until it answers a byte with NACK. The internal address stays where the last transfer left it.

SCL and SDA pass through two-flop synchronizers and are sampled on the system clock. START and STOP are seen as SDA edges while SCL is high. SDA is open drain: the block only ever pulls it low.

Top module: `osd_i2c_slave`

## Requirements
- R1: The device answers only the address byte 0xBA (write) or 0xBB (read), i.e. the 7-bit address 1011101 with R/W in bit 0. Any other address byte gets no acknowledge, and the rest of that transfer causes no bus strobe and no SDA drive.
- R2: In a write transfer the first byte after the device address is address bits 7..0 and the second is address bits 13..8, taken from its bits 5..0 (bits 7..6 ignored). Each following data byte, received MSB first, is written with a single one-cycle mem_we pulse to the current address, which then increments.
- R3: The slave pulls SDA low in the ninth clock of every byte it accepts: the matching device address, both address bytes and every written data byte.
- R4: A read transfer returns, MSB first, the bytes at successive addresses starting at the stored address. Each byte is fetched with a one-cycle mem_re pulse, and mem_rdata is taken two cycles after that pulse.
- R5: A NACK from the master ends the read stream and releases SDA, with no further mem_re. The stored address then points one past the last byte sent, so a later read transfer continues from there.
- R6: Data bytes sent to ROM addresses (0x2000–0x32FF) or to empty addresses are acknowledged but produce no mem_we. The address still increments.
- R7: Reads from empty addresses (0x0400–0x1FFF and 0x3300–0x3FEF) return 0x00 and produce no mem_re.
- R8: A STOP at any point returns the slave to idle with SDA released. A START, including a repeated START without a STOP, restarts reception at the device address byte.
- R9: The internal address wraps from 0x3FFF to 0x0000 during both writes and reads.
- R10: After reset, SDA is released and neither mem_re nor mem_we is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low |
| mem_re | output | 1 | One-cycle read strobe |
| mem_we | output | 1 | One-cycle write strobe |
| mem_addr | output | 14 | Address for the strobe |
| mem_wdata | output | 8 | Write data, valid with mem_we |
| mem_rdata | input | 8 | Read data, returned the cycle after mem_re |

## Verification
The bench works at SCL-bit level. It changes SDA only while SCL is low and samples SDA in the middle of the SCL high phase. Every slave response therefore has several system cycles to pass through the two-flop synchronizer, the edge detector and the output register, and the three-cycle lag is never close to the sampling point. Each read byte is fetched as soon as the previous acknowledge is seen. Its data is held in the slave two cycles after mem_re and is shifted out at the next SCL fall, so reads are checked only in the following byte slot. Strobe counts and memory contents are compared only after the STOP that ends a transfer, when every write strobe has already fired.

// File: rtl/osd_i2c_slave.sv
module osd_i2c_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h5D,
  parameter int AW = 14,
  parameter int DW = 8,
  parameter logic [AW-1:0] RAM_TOP = 14'h03FF,
  parameter logic [AW-1:0] ROM_LO  = 14'h2000,
  parameter logic [AW-1:0] ROM_HI  = 14'h32FF,
  parameter logic [AW-1:0] REG_LO  = 14'h3FF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic          mem_re,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  typedef enum logic [2:0] {PH_IDLE, PH_DEV, PH_ALO, PH_AHI, PH_WR, PH_RD} phase_t;

  phase_t          ph;
  logic            scl_m, scl_s, scl_q, sda_m, sda_s, sda_q;
  logic [3:0]      bitcnt;
  logic [DW-1:0]   sr, rbuf;
  logic [AW-1:0]   addr;
  logic            ack_drv, rp1, rp2;

  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  wire in_ram  = addr <= RAM_TOP;
  wire in_rom  = (addr >= ROM_LO) && (addr <= ROM_HI);
  wire in_reg  = addr >= REG_LO;
  wire wr_ok   = in_ram | in_reg;
  wire rd_ok   = wr_ok | in_rom;
  wire dev_hit = sr[7:1] == DEV_ADDR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {scl_m, scl_s, scl_q} <= 3'b111;
      {sda_m, sda_s, sda_q} <= 3'b111;
    end else begin
      {scl_q, scl_s, scl_m} <= {scl_s, scl_m, scl_i};
      {sda_q, sda_s, sda_m} <= {sda_s, sda_m, sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      bitcnt    <= '0;
      sr        <= '0;
      rbuf      <= '0;
      addr      <= '0;
      ack_drv   <= 1'b0;
      rp1       <= 1'b0;
      rp2       <= 1'b0;
      sda_oe    <= 1'b0;
      mem_re    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_re <= 1'b0;
      mem_we <= 1'b0;
      rp1    <= 1'b0;
      rp2    <= rp1;
      if (rp2) rbuf <= mem_rdata;

      if (start_c || stop_c) begin
        ph      <= start_c ? PH_DEV : PH_IDLE;
        bitcnt  <= '0;
        ack_drv <= 1'b0;
        sda_oe  <= 1'b0;
      end else begin
        case (ph)
          PH_IDLE: ;
          PH_RD: begin
            if (scl_fall) begin
              if (bitcnt < 4'd7) begin
                sr     <= {sr[DW-2:0], 1'b0};
                sda_oe <= ~sr[DW-2];
                bitcnt <= bitcnt + 4'd1;
              end else if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                bitcnt <= 4'd8;
              end else if (bitcnt == 4'd9) begin
                sr     <= rbuf;
                sda_oe <= ~rbuf[DW-1];
                addr   <= addr + 1'b1;
                bitcnt <= '0;
              end
            end else if (scl_rise && bitcnt == 4'd8) begin
              if (sda_s) begin
                ph <= PH_IDLE;
              end else begin
                bitcnt <= 4'd9;
                if (rd_ok) begin
                  mem_re   <= 1'b1;
                  mem_addr <= addr;
                  rp1      <= 1'b1;
                end else begin
                  rbuf <= '0;
                end
              end
            end
          end
          default: begin
            if (scl_rise && bitcnt < 4'd8) begin
              sr     <= {sr[DW-2:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && ack_drv) begin
              ack_drv <= 1'b0;
              sda_oe  <= 1'b0;
              bitcnt  <= '0;
              case (ph)
                PH_DEV: begin
                  if (sr[0]) begin
                    ph     <= PH_RD;
                    sr     <= rbuf;
                    sda_oe <= ~rbuf[DW-1];
                    addr   <= addr + 1'b1;
                  end else begin
                    ph <= PH_ALO;
                  end
                end
                PH_ALO:  ph <= PH_AHI;
                PH_AHI:  ph <= PH_WR;
                default: ;
              endcase
            end else if (scl_fall && bitcnt == 4'd8) begin
              ack_drv <= 1'b1;
              sda_oe  <= 1'b1;
              case (ph)
                PH_DEV: begin
                  if (!dev_hit) begin
                    ack_drv <= 1'b0;
                    sda_oe  <= 1'b0;
                    ph      <= PH_IDLE;
                  end else if (sr[0]) begin
                    if (rd_ok) begin
                      mem_re   <= 1'b1;
                      mem_addr <= addr;
                      rp1      <= 1'b1;
                    end else begin
                      rbuf <= '0;
                    end
                  end
                end
                PH_ALO: addr[7:0] <= sr;
                PH_AHI: addr[AW-1:8] <= sr[AW-9:0];
                default: begin
                  mem_we    <= wr_ok;
                  mem_addr  <= addr;
                  mem_wdata <= sr;
                  addr      <= addr + 1'b1;
                end
              endcase
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/osd_i2c_slave_chk.sv
module osd_i2c_slave_chk #(
  parameter int AW = 14,
  parameter logic [AW-1:0] RAM_TOP = 14'h03FF,
  parameter logic [AW-1:0] ROM_LO  = 14'h2000,
  parameter logic [AW-1:0] ROM_HI  = 14'h32FF,
  parameter logic [AW-1:0] REG_LO  = 14'h3FF0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          mem_re,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr
);

  wire a_ram = mem_addr <= RAM_TOP;
  wire a_rom = (mem_addr >= ROM_LO) && (mem_addr <= ROM_HI);
  wire a_reg = mem_addr >= REG_LO;

  // R6: write strobes only reach RAM or registers
  a_r6_we_region: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (a_ram || a_reg));

  // R7: read strobes never reach empty space
  a_r7_re_region: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (a_ram || a_rom || a_reg));

  // R2: a write strobe is a single-cycle pulse and never overlaps a read
  a_r2_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we && !mem_re);

  // R4: a read strobe is a single-cycle pulse
  a_r4_re_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !mem_re);

  // R3: SDA drive changes only while the synchronized SCL is low
  a_r3_sda_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

endmodule

bind osd_i2c_slave osd_i2c_slave_chk #(
  .AW(AW), .RAM_TOP(RAM_TOP), .ROM_LO(ROM_LO), .ROM_HI(ROM_HI), .REG_LO(REG_LO)
) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/osd_i2c_slave_tb_top.sv
module osd_i2c_slave_tb_top;
  localparam int Q = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, mem_re, mem_we;
  logic [13:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  wire sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  osd_i2c_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [7:0] mem  [0:16383];
  logic [7:0] emem [0:16383];
  int we_cnt = 0, re_cnt = 0, n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    if (mem_we) begin mem[mem_addr] <= mem_wdata; we_cnt <= we_cnt + 1; end
    if (mem_re) begin mem_rdata <= mem[mem_addr]; re_cnt <= re_cnt + 1; end
  end

  function automatic logic [7:0] pat(input logic [13:0] a);
    return a[7:0] ^ {a[13:8], 2'b01};
  endfunction
  function automatic bit wr_ok(input logic [13:0] a);
    return (a <= 14'h03FF) || (a >= 14'h3FF0);
  endfunction
  function automatic bit rd_ok(input logic [13:0] a);
    return wr_ok(a) || (a >= 14'h2000 && a <= 14'h32FF);
  endfunction
  function automatic logic [7:0] expv(input logic [13:0] a);
    return rd_ok(a) ? emem[a] : 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask
  task automatic i_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask
  task automatic wbit(input bit b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask
  task automatic rbit(output bit b);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask
  task automatic wbyte(input logic [7:0] d, output bit ack);
    bit a;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(a);
    ack = !a;
  endtask
  task automatic rbyte(input bit last, output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    wbit(last);
  endtask

  task automatic set_addr(input logic [7:0] lo, input logic [7:0] hi, input bit stop);
    bit ack;
    i_start();
    wbyte(8'hBA, ack); chk("R3 dev write ack", ack, 1);
    wbyte(lo, ack);    chk("R3 addr lo ack", ack, 1);
    wbyte(hi, ack);    chk("R3 addr hi ack", ack, 1);
    if (stop) i_stop();
  endtask

  task automatic write_seq(input logic [7:0] lo, input logic [7:0] hi, input int n,
                           input logic [7:0] d0, input string tag);
    bit ack;
    logic [13:0] a;
    logic [7:0] d;
    set_addr(lo, hi, 1'b0);
    a = {hi[5:0], lo};
    for (int i = 0; i < n; i++) begin
      d = d0 + 8'(i * 37);
      wbyte(d, ack);
      chk({tag, " R3 data ack"}, ack, 1);
      if (wr_ok(a)) emem[a] = d;
      a = a + 14'd1;
    end
    i_stop();
  endtask

  task automatic read_seq(input int n, input logic [13:0] base, input string tag);
    bit ack;
    logic [7:0] d;
    logic [13:0] a;
    a = base;
    i_start();
    wbyte(8'hBB, ack); chk({tag, " R1 dev read ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      rbyte(i == n - 1, d);
      chk({tag, " R4 read data"}, d, expv(a));
      a = a + 14'd1;
    end
    i_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit ack;
    int w0, r0;
    logic [7:0] d;
    logic [13:0] a;
    void'($urandom(32'h1D5A));
    for (int i = 0; i < 16384; i++) begin mem[i] = pat(14'(i)); emem[i] = pat(14'(i)); end
    tick(3);
    chk("R10 sda released in reset", sda_oe, 0);
    chk("R10 no strobes in reset", {mem_re, mem_we}, 0);
    rst_n = 1'b1;
    tick(10);
    chk("R10 idle after reset", {sda_oe, mem_re, mem_we}, 0);

    // R1: foreign address is ignored
    w0 = we_cnt; r0 = re_cnt;
    i_start();
    wbyte(8'hA0, ack); chk("R1 foreign address nack", ack, 0);
    wbyte(8'h55, ack); chk("R1 later byte nack", ack, 0);
    i_stop();
    chk("R1 no strobes", {we_cnt - w0, re_cnt - r0}, 0);

    // R2/R3/R4: RAM write with ignored top bits of the high byte, then read back
    write_seq(8'h10, 8'hC0, 4, 8'h3C, "R2");
    chk("R2 stored at 0x0010", mem[14'h0010], 8'h3C);
    chk("R2 stored at 0x0013", mem[14'h0013], emem[14'h0013]);
    set_addr(8'h10, 8'h00, 1'b1);
    read_seq(4, 14'h0010, "R4");

    // R6: ROM and empty writes are acknowledged and dropped
    w0 = we_cnt;
    write_seq(8'h00, 8'h21, 3, 8'hF0, "R6 rom");
    write_seq(8'h00, 8'h10, 2, 8'h11, "R6 empty");
    chk("R6 no mem_we", we_cnt - w0, 0);
    set_addr(8'h00, 8'h21, 1'b1);
    read_seq(3, 14'h2100, "R6 rom unchanged");

    // R7: empty reads give zero with no bus read
    set_addr(8'h00, 8'h10, 1'b1);
    r0 = re_cnt;
    read_seq(3, 14'h1000, "R7");
    chk("R7 no mem_re", re_cnt - r0, 0);

    // R5: NACK ends the stream, next read resumes one past
    set_addr(8'h20, 8'h00, 1'b1);
    read_seq(3, 14'h0020, "R5");
    chk("R5 sda released after nack", sda_oe, 0);
    r0 = re_cnt;
    tick(50);
    chk("R5 no reads after nack", re_cnt - r0, 0);
    read_seq(1, 14'h0023, "R5 resume");

    // R9: wrap at top of address space
    write_seq(8'hFF, 8'h3F, 2, 8'hA7, "R9");
    chk("R9 wrapped write to 0x0000", mem[14'h0000], emem[14'h0000]);
    set_addr(8'hFF, 8'h3F, 1'b1);
    read_seq(2, 14'h3FFF, "R9 wrapped read");

    // R8: repeated START switches to read without STOP
    set_addr(8'h40, 8'h00, 1'b0);
    read_seq(2, 14'h0040, "R8 repeated start");
    // R8: STOP in the middle of a byte aborts cleanly
    w0 = we_cnt;
    set_addr(8'h50, 8'h00, 1'b0);
    wbit(1); wbit(0); wbit(1); wbit(1);
    i_stop();
    chk("R8 sda released after stop", sda_oe, 0);
    chk("R8 partial byte not written", we_cnt - w0, 0);
    write_seq(8'h50, 8'h00, 1, 8'h99, "R8 after abort");
    chk("R8 write after abort", mem[14'h0050], 8'h99);

    // random mix across regions
    for (int it = 0; it < 16; it++) begin
      int reg_sel, n;
      reg_sel = int'($urandom_range(0, 3));
      n = int'($urandom_range(1, 4));
      case (reg_sel)
        0: a = 14'($urandom_range(0, 14'h03FF));
        1: a = 14'($urandom_range(14'h3FF0, 14'h3FFF));
        2: a = 14'($urandom_range(14'h2000, 14'h32FF));
        default: a = 14'($urandom_range(14'h0400, 14'h1FFF));
      endcase
      d = 8'($urandom);
      write_seq(a[7:0], {2'b00, a[13:8]}, n, d, "R2 random");
      set_addr(a[7:0], {2'b00, a[13:8]}, 1'b0);
      read_seq(n, a, "R4 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule